// File: doc/BRIEF.md
# Dispatch-Stage Instruction Window with Drain-to-Shadow Exceptions

This block holds the instructions that the fetch side has delivered but that have not yet left the machine for good. Entries arrive in program order, are issued in program order once an external hazard check says the operands are ready, and each issued entry gets a tag that no other in-flight entry holds. Execution units report back by tag, in any order. A successful report removes the entry at once, wherever it sits. Instructions flagged as never faulting leave the window as soon as they issue. The window compacts after every removal, so the oldest live entry is always in slot 0.

A fault report keeps the entry and stores its status code and both source operands. From that cycle on nothing more is issued. The window waits until every issued entry has either succeeded or faulted. It then copies itself into a shadow copy that a handler can read, empties itself, and raises a one-cycle entry pulse. The shadow therefore holds only faulted and never-issued entries, still in program order. A return request reloads the window from the shadow. Faulted entries, which the handler is expected to have emulated, are left out of the reload. Issuing resumes, and exceptions are enabled again.

Top module: `iwin_top`

## Requirements
- R1: After reset the window is empty (`winCount`=0), `fetchReady`=1, and `issueValid`, `excEnter`, `excActive` and `prefetchHold` are all 0.
- R2: A fetch with `fetchValid`=1 while `fetchReady`=1 adds one entry after the clock edge. With SLOTS entries held, `fetchReady` is 0.
- R3: `issueValid`, `issueAddr` and `issueOpcode` present the oldest entry not yet issued. It is issued only on an edge where `issueReady`=1.
- R4: An issued entry that may fault takes the lowest-numbered tag not held by any in-flight entry. A tag becomes free again only when its entry completes successfully or when exception entry occurs.
- R5: A completion with `cmplFault`=0 that matches an in-flight tag removes that entry after the edge, at any position. The relative order of the other entries is kept.
- R6: An entry fetched with `fetchSafe`=1 is removed on the edge where it issues and consumes no tag.
- R7: An entry fetched with `fetchHeadOnly`=1 is offered for issue only while it is in slot 0.
- R8: A completion with `cmplFault`=1 keeps its entry and records `cmplStatus`, `cmplArg1` and `cmplArg2`. No issue takes place in that cycle or afterwards until return. Exception entry waits while any issued entry has not reported.
- R9: On the edge after the last outstanding entry reports, the window empties and `excEnter` is 1 for exactly one cycle. `excActive` rises at the same time. `shadowCount` and the shadow read port (`shadowSel`) then give the faulted and never-issued entries in program order. `shadowFaulted`=1 marks a faulted entry, which carries its status and operands.
- R10: While `excActive`=1, `fetchReady` and `issueValid` are 0 and a fetch attempt adds nothing.
- R11: `rteReq`=1 while `excActive`=1 clears `excActive` on the edge. It reloads the never-issued shadow entries into slots 0 upward in order, drops the faulted ones, and lets issuing resume.
- R12: `prefetchHold` is 1 exactly while some entry in the window was fetched with `fetchHoldPrefetch`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | Fetched instruction offered |
| fetchReady | output | 1 | Window can take a fetched instruction |
| fetchAddr | input | 30 | Instruction word address |
| fetchOpcode | input | 32 | Instruction word |
| fetchHeadOnly | input | 1 | Issue only from slot 0 |
| fetchHoldPrefetch | input | 1 | Entry inhibits prefetch while held |
| fetchSafe | input | 1 | Instruction can never fault |
| issueReady | input | 1 | Hazard check passed, issue may happen |
| issueValid | output | 1 | An entry is offered for issue |
| issueTag | output | 4 | Tag given to the offered entry |
| issueAddr | output | 30 | Address of the offered entry |
| issueOpcode | output | 32 | Opcode of the offered entry |
| cmplValid | input | 1 | Completion report valid |
| cmplTag | input | 4 | Tag of the reporting instruction |
| cmplFault | input | 1 | Report is a fault |
| cmplStatus | input | 8 | Fault status code |
| cmplArg1 | input | 32 | First saved operand |
| cmplArg2 | input | 32 | Second saved operand |
| rteReq | input | 1 | Return from exception |
| excEnter | output | 1 | One-cycle exception entry pulse |
| excActive | output | 1 | Exception handling in progress |
| shadowSel | input | 3 | Shadow entry to read |
| shadowCount | output | 4 | Entries held in the shadow |
| shadowAddr | output | 30 | Selected shadow entry address |
| shadowOpcode | output | 32 | Selected shadow entry opcode |
| shadowFaulted | output | 1 | Selected shadow entry faulted |
| shadowStatus | output | 8 | Selected shadow entry status |
| shadowArg1 | output | 32 | Selected shadow entry first operand |
| shadowArg2 | output | 32 | Selected shadow entry second operand |
| winCount | output | 4 | Entries held in the window |
| prefetchHold | output | 1 | Some held entry inhibits prefetch |

## Verification
Fetch, issue, completion and return each change `winCount` one edge after the cycle that presents them. The issue offer and the shadow read port are combinational on the current state. `excEnter` lags the last outstanding report by one edge, because the entry decision is taken from the registered draining flag. The bench drives every input on a falling edge and samples on the next falling edge, so each result is read exactly one register stage after its cause. For fault handling it checks the cycle between the last report and the entry pulse explicitly, to catch an entry that arrives one cycle early or late.

// File: rtl/iwin_pkg.sv
package iwin_pkg;
  localparam int ADDR_W = 30;
  localparam int OPC_W  = 32;
  localparam int ARG_W  = 32;
  localparam int STAT_W = 8;
  localparam int TAG_W  = 4;
  localparam int TAGS   = 1 << TAG_W;

  typedef logic [TAG_W-1:0] tag_t;

  typedef struct packed {
    logic              valid;
    tag_t              tag;
    logic [ADDR_W-1:0] addr;
    logic [OPC_W-1:0]  opcode;
    logic              headOnly;
    logic              holdFetch;
    logic              safe;
    logic              issued;
    logic              faulted;
    logic [STAT_W-1:0] status;
    logic [ARG_W-1:0]  arg1;
    logic [ARG_W-1:0]  arg2;
  } slot_t;

  typedef struct packed {
    logic fetchGo;
    logic issueGo;
    logic issueDrop;
    tag_t issueTag;
    logic cmplHit;
    logic cmplFault;
    logic enter;
    logic restore;
  } strobe_t;
endpackage

// File: rtl/iwin_ctrl.sv
module iwin_ctrl
  import iwin_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int IDX_W = $clog2(SLOTS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [SLOTS-1:0]            validVec,
  input  logic [SLOTS-1:0]            issuedVec,
  input  logic [SLOTS-1:0]            faultedVec,
  input  logic [SLOTS-1:0]            headVec,
  input  logic [SLOTS-1:0]            safeVec,
  input  logic [SLOTS-1:0][TAG_W-1:0] tagVec,
  input  logic                        winFull,
  input  logic                        fetchValid,
  input  logic                        issueReady,
  input  logic                        cmplValid,
  input  tag_t                        cmplTag,
  input  logic                        cmplFault,
  input  logic                        rteReq,
  output strobe_t                     stb,
  output logic [IDX_W-1:0]            issueIdx,
  output logic [IDX_W-1:0]            cmplIdx,
  output logic                        fetchReady,
  output logic                        issueValid,
  output logic                        excEnter,
  output logic                        excActive
);
  logic            draining;
  logic [TAGS-1:0] freeMask;
  logic            candFound, tagFound, hitAny, outstanding, faultNow, enterNow;
  tag_t            freeTag;

  always_comb begin
    candFound = 1'b0;
    issueIdx  = '0;
    for (int i = 0; i < SLOTS; i++)
      if (!candFound && validVec[i] && !issuedVec[i]) begin
        candFound = 1'b1;
        issueIdx  = IDX_W'(i);
      end
  end

  always_comb begin
    tagFound = 1'b0;
    freeTag  = '0;
    for (int t = 0; t < TAGS; t++)
      if (!tagFound && freeMask[t]) begin
        tagFound = 1'b1;
        freeTag  = tag_t'(t);
      end
  end

  always_comb begin
    hitAny  = 1'b0;
    cmplIdx = '0;
    for (int i = 0; i < SLOTS; i++)
      if (!hitAny && cmplValid && validVec[i] && issuedVec[i] && !faultedVec[i]
          && tagVec[i] == cmplTag) begin
        hitAny  = 1'b1;
        cmplIdx = IDX_W'(i);
      end
  end

  assign outstanding = |(validVec & issuedVec & ~faultedVec);
  assign faultNow    = hitAny && cmplFault;
  assign enterNow    = draining && !outstanding;
  assign fetchReady  = !winFull && !draining && !excActive;
  assign issueValid  = candFound && tagFound && !draining && !excActive && !faultNow
                       && (!headVec[issueIdx] || issueIdx == '0);

  always_comb begin
    stb           = '0;
    stb.fetchGo   = fetchValid && fetchReady;
    stb.issueGo   = issueValid && issueReady;
    stb.issueDrop = stb.issueGo && safeVec[issueIdx];
    stb.issueTag  = freeTag;
    stb.cmplHit   = hitAny;
    stb.cmplFault = cmplFault;
    stb.enter     = enterNow;
    stb.restore   = excActive && rteReq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      draining  <= 1'b0;
      excActive <= 1'b0;
      excEnter  <= 1'b0;
      freeMask  <= '1;
    end else begin
      excEnter <= enterNow;
      if (enterNow)      draining <= 1'b0;
      else if (faultNow) draining <= 1'b1;
      if (enterNow)          excActive <= 1'b1;
      else if (stb.restore)  excActive <= 1'b0;
      if (enterNow) freeMask <= '1;
      else begin
        if (hitAny && !cmplFault) freeMask[cmplTag] <= 1'b1;
        if (stb.issueGo && !stb.issueDrop) freeMask[freeTag] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/iwin_data.sv
module iwin_data
  import iwin_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int IDX_W = $clog2(SLOTS),
  parameter int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  strobe_t                     stb,
  input  logic [IDX_W-1:0]            issueIdx,
  input  logic [IDX_W-1:0]            cmplIdx,
  input  logic [ADDR_W-1:0]           fetchAddr,
  input  logic [OPC_W-1:0]            fetchOpcode,
  input  logic                        fetchHeadOnly,
  input  logic                        fetchHoldPrefetch,
  input  logic                        fetchSafe,
  input  logic [STAT_W-1:0]           cmplStatus,
  input  logic [ARG_W-1:0]            cmplArg1,
  input  logic [ARG_W-1:0]            cmplArg2,
  input  logic [IDX_W-1:0]            shadowSel,
  output logic [SLOTS-1:0]            validVec,
  output logic [SLOTS-1:0]            issuedVec,
  output logic [SLOTS-1:0]            faultedVec,
  output logic [SLOTS-1:0]            headVec,
  output logic [SLOTS-1:0]            safeVec,
  output logic [SLOTS-1:0][TAG_W-1:0] tagVec,
  output logic [CNT_W-1:0]            winCount,
  output logic                        prefetchHold,
  output logic [ADDR_W-1:0]           issueAddr,
  output logic [OPC_W-1:0]            issueOpcode,
  output logic [CNT_W-1:0]            shadowCount,
  output logic [ADDR_W-1:0]           shadowAddr,
  output logic [OPC_W-1:0]            shadowOpcode,
  output logic                        shadowFaulted,
  output logic [STAT_W-1:0]           shadowStatus,
  output logic [ARG_W-1:0]            shadowArg1,
  output logic [ARG_W-1:0]            shadowArg2
);
  slot_t [SLOTS-1:0] slots, shadow, work, src, nxt;
  logic  [SLOTS-1:0] keep;
  logic  [CNT_W-1:0] pos;
  slot_t             fresh;

  always_comb begin
    fresh           = '0;
    fresh.valid     = 1'b1;
    fresh.addr      = fetchAddr;
    fresh.opcode    = fetchOpcode;
    fresh.headOnly  = fetchHeadOnly;
    fresh.holdFetch = fetchHoldPrefetch;
    fresh.safe      = fetchSafe;
  end

  always_comb begin
    work = slots;
    if (stb.issueGo) begin
      work[issueIdx].issued = 1'b1;
      work[issueIdx].tag    = stb.issueTag;
    end
    if (stb.cmplHit && stb.cmplFault) begin
      work[cmplIdx].faulted = 1'b1;
      work[cmplIdx].status  = cmplStatus;
      work[cmplIdx].arg1    = cmplArg1;
      work[cmplIdx].arg2    = cmplArg2;
    end
    src = stb.restore ? shadow : work;
    for (int i = 0; i < SLOTS; i++) begin
      if (stb.restore) keep[i] = shadow[i].valid && !shadow[i].issued;
      else keep[i] = work[i].valid
          && !(stb.cmplHit && !stb.cmplFault && cmplIdx == IDX_W'(i))
          && !(stb.issueDrop && issueIdx == IDX_W'(i));
    end
    nxt = '0;
    pos = '0;
    for (int i = 0; i < SLOTS; i++)
      if (keep[i]) begin
        nxt[pos[IDX_W-1:0]] = src[i];
        pos = pos + CNT_W'(1);
      end
    if (stb.fetchGo) nxt[pos[IDX_W-1:0]] = fresh;
    if (stb.enter) nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slots       <= '0;
      shadow      <= '0;
      shadowCount <= '0;
    end else begin
      slots <= nxt;
      if (stb.enter) begin
        shadow      <= slots;
        shadowCount <= winCount;
      end
    end
  end

  always_comb begin
    winCount     = '0;
    prefetchHold = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      validVec[i]   = slots[i].valid;
      issuedVec[i]  = slots[i].issued;
      faultedVec[i] = slots[i].faulted;
      headVec[i]    = slots[i].headOnly;
      safeVec[i]    = slots[i].safe;
      tagVec[i]     = slots[i].tag;
      winCount      = winCount + CNT_W'(slots[i].valid);
      prefetchHold  = prefetchHold | (slots[i].valid & slots[i].holdFetch);
    end
  end

  assign issueAddr     = slots[issueIdx].addr;
  assign issueOpcode   = slots[issueIdx].opcode;
  assign shadowAddr    = shadow[shadowSel].addr;
  assign shadowOpcode  = shadow[shadowSel].opcode;
  assign shadowFaulted = shadow[shadowSel].faulted;
  assign shadowStatus  = shadow[shadowSel].status;
  assign shadowArg1    = shadow[shadowSel].arg1;
  assign shadowArg2    = shadow[shadowSel].arg2;
endmodule

// File: rtl/iwin_top.sv
module iwin_top
  import iwin_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int IDX_W = $clog2(SLOTS),
  parameter int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetchValid,
  output logic              fetchReady,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [OPC_W-1:0]  fetchOpcode,
  input  logic              fetchHeadOnly,
  input  logic              fetchHoldPrefetch,
  input  logic              fetchSafe,
  input  logic              issueReady,
  output logic              issueValid,
  output logic [TAG_W-1:0]  issueTag,
  output logic [ADDR_W-1:0] issueAddr,
  output logic [OPC_W-1:0]  issueOpcode,
  input  logic              cmplValid,
  input  logic [TAG_W-1:0]  cmplTag,
  input  logic              cmplFault,
  input  logic [STAT_W-1:0] cmplStatus,
  input  logic [ARG_W-1:0]  cmplArg1,
  input  logic [ARG_W-1:0]  cmplArg2,
  input  logic              rteReq,
  output logic              excEnter,
  output logic              excActive,
  input  logic [IDX_W-1:0]  shadowSel,
  output logic [CNT_W-1:0]  shadowCount,
  output logic [ADDR_W-1:0] shadowAddr,
  output logic [OPC_W-1:0]  shadowOpcode,
  output logic              shadowFaulted,
  output logic [STAT_W-1:0] shadowStatus,
  output logic [ARG_W-1:0]  shadowArg1,
  output logic [ARG_W-1:0]  shadowArg2,
  output logic [CNT_W-1:0]  winCount,
  output logic              prefetchHold
);
  strobe_t                     stb;
  logic [IDX_W-1:0]            issueIdx, cmplIdx;
  logic [SLOTS-1:0]            validVec, issuedVec, faultedVec, headVec, safeVec;
  logic [SLOTS-1:0][TAG_W-1:0] tagVec;

  assign issueTag = stb.issueTag;

  iwin_ctrl #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .validVec(validVec), .issuedVec(issuedVec),
    .faultedVec(faultedVec), .headVec(headVec), .safeVec(safeVec), .tagVec(tagVec),
    .winFull(winCount == CNT_W'(SLOTS)), .fetchValid(fetchValid), .issueReady(issueReady),
    .cmplValid(cmplValid), .cmplTag(cmplTag), .cmplFault(cmplFault), .rteReq(rteReq),
    .stb(stb), .issueIdx(issueIdx), .cmplIdx(cmplIdx), .fetchReady(fetchReady),
    .issueValid(issueValid), .excEnter(excEnter), .excActive(excActive)
  );

  iwin_data #(.SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_data (
    .clk(clk), .rst_n(rst_n), .stb(stb), .issueIdx(issueIdx), .cmplIdx(cmplIdx),
    .fetchAddr(fetchAddr), .fetchOpcode(fetchOpcode), .fetchHeadOnly(fetchHeadOnly),
    .fetchHoldPrefetch(fetchHoldPrefetch), .fetchSafe(fetchSafe),
    .cmplStatus(cmplStatus), .cmplArg1(cmplArg1), .cmplArg2(cmplArg2),
    .shadowSel(shadowSel), .validVec(validVec), .issuedVec(issuedVec),
    .faultedVec(faultedVec), .headVec(headVec), .safeVec(safeVec), .tagVec(tagVec),
    .winCount(winCount), .prefetchHold(prefetchHold), .issueAddr(issueAddr),
    .issueOpcode(issueOpcode), .shadowCount(shadowCount), .shadowAddr(shadowAddr),
    .shadowOpcode(shadowOpcode), .shadowFaulted(shadowFaulted),
    .shadowStatus(shadowStatus), .shadowArg1(shadowArg1), .shadowArg2(shadowArg2)
  );
endmodule

// File: rtl/iwin_chk.sv
module iwin_chk #(
  parameter int SLOTS = 8,
  parameter int CNT_W = $clog2(SLOTS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fetchValid,
  input logic             fetchReady,
  input logic             issueValid,
  input logic             cmplValid,
  input logic             rteReq,
  input logic             excEnter,
  input logic             excActive,
  input logic [CNT_W-1:0] winCount
);
  p_full_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    winCount == CNT_W'(SLOTS) |-> !fetchReady);

  p_fetch_adds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetchValid && fetchReady && !issueValid && !cmplValid)
    |=> winCount == CNT_W'($past(winCount) + CNT_W'(1)));

  p_enter_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    excEnter |=> !excEnter);

  p_enter_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    excEnter |-> (winCount == '0 && excActive));

  p_exc_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    excActive |-> (!fetchReady && !issueValid));

  p_return_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (excActive && rteReq) |=> !excActive);
endmodule

bind iwin_top iwin_chk #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_iwin_top.sv
`timescale 1ns/1ps
module sim_iwin_top;
  import iwin_pkg::*;
  localparam int SLOTS = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fetchValid, fetchReady, fetchHeadOnly, fetchHoldPrefetch, fetchSafe;
  logic [ADDR_W-1:0] fetchAddr, issueAddr, shadowAddr;
  logic [OPC_W-1:0]  fetchOpcode, issueOpcode, shadowOpcode;
  logic issueReady, issueValid, cmplValid, cmplFault, rteReq, excEnter, excActive;
  logic [TAG_W-1:0]  issueTag, cmplTag;
  logic [STAT_W-1:0] cmplStatus, shadowStatus;
  logic [ARG_W-1:0]  cmplArg1, cmplArg2, shadowArg1, shadowArg2;
  logic [2:0] shadowSel;
  logic [3:0] shadowCount, winCount;
  logic shadowFaulted, prefetchHold;
  int total = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  iwin_top #(.SLOTS(SLOTS)) u0 (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; fetchValid = 0; fetchAddr = '0; fetchOpcode = '0; fetchHeadOnly = 0;
    fetchHoldPrefetch = 0; fetchSafe = 0; issueReady = 0; cmplValid = 0; cmplTag = '0;
    cmplFault = 0; cmplStatus = '0; cmplArg1 = '0; cmplArg2 = '0; rteReq = 0; shadowSel = '0;
    step(); step();
    rst_n = 1;
    step();
  endtask

  task automatic fetch(input logic [29:0] a, input logic head, input logic hold, input logic safe);
    fetchValid = 1; fetchAddr = a; fetchOpcode = {2'b10, a};
    fetchHeadOnly = head; fetchHoldPrefetch = hold; fetchSafe = safe;
    step();
    fetchValid = 0; fetchHeadOnly = 0; fetchHoldPrefetch = 0; fetchSafe = 0;
  endtask

  task automatic issue(input string req, input logic [3:0] tag, input logic [29:0] a);
    chk({req, " offer"}, issueValid, 1);
    chk({req, " tag"}, issueTag, tag);
    chk({req, " addr"}, issueAddr, a);
    chk({req, " opcode"}, issueOpcode, {2'b10, a});
    issueReady = 1;
    step();
    issueReady = 0;
  endtask

  task automatic report(input logic [3:0] tag, input logic flt, input logic [7:0] st,
                        input logic [31:0] a1, input logic [31:0] a2);
    cmplValid = 1; cmplTag = tag; cmplFault = flt; cmplStatus = st; cmplArg1 = a1; cmplArg2 = a2;
    step();
    cmplValid = 0; cmplFault = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 count", winCount, 0);
    chk("R1 fetchReady", fetchReady, 1);
    chk("R1 issueValid", issueValid, 0);
    chk("R1 excEnter", excEnter, 0);
    chk("R1 excActive", excActive, 0);
    chk("R1 prefetchHold", prefetchHold, 0);
  endtask

  task automatic t_fill_and_order();
    do_reset();
    for (int i = 0; i < SLOTS; i++) fetch(30'h100 + 30'(i), 0, 0, 0);
    chk("R2 full count", winCount, SLOTS);
    chk("R2 full blocks", fetchReady, 0);
    step();
    chk("R3 no issue without ready", winCount, SLOTS);
    issue("R3 R4 first", 0, 30'h100);
    issue("R3 R4 second", 1, 30'h101);
    issue("R3 R4 third", 2, 30'h102);
    report(1, 0, 0, 0, 0);
    chk("R5 middle removed", winCount, SLOTS - 1);
    chk("R2 room again", fetchReady, 1);
    issue("R4 lowest free tag reused", 1, 30'h103);
    report(0, 0, 0, 0, 0);
    report(2, 0, 0, 0, 0);
    chk("R5 count after removals", winCount, SLOTS - 3);
    chk("R5 order kept", issueAddr, 30'h104);
  endtask

  task automatic t_safe();
    do_reset();
    fetch(30'h200, 0, 0, 1);
    fetch(30'h201, 0, 0, 0);
    issue("R6 safe issue", 0, 30'h200);
    chk("R6 removed at issue", winCount, 1);
    issue("R6 no tag used", 0, 30'h201);
  endtask

  task automatic t_head_only();
    do_reset();
    fetch(30'h300, 0, 0, 0);
    fetch(30'h301, 1, 1, 0);
    chk("R12 hold set", prefetchHold, 1);
    issue("R7 older first", 0, 30'h300);
    chk("R7 held off slot0", issueValid, 0);
    report(0, 0, 0, 0, 0);
    chk("R7 count", winCount, 1);
    issue("R7 at slot0", 0, 30'h301);
    chk("R12 hold while issued", prefetchHold, 1);
    report(0, 0, 0, 0, 0);
    chk("R12 hold clear", prefetchHold, 0);
  endtask

  task automatic t_fault_drain();
    do_reset();
    for (int i = 0; i < 5; i++) fetch(30'h40 + 30'(i), 0, 0, 0);
    issue("R3 A", 0, 30'h40);
    issue("R3 B", 1, 30'h41);
    issue("R3 C", 2, 30'h42);
    report(1, 1, 8'h5A, 32'h1111, 32'h2222);
    chk("R8 fault stops issue", issueValid, 0);
    chk("R8 fault keeps entry", winCount, 5);
    chk("R8 no entry yet", excEnter, 0);
    report(2, 0, 0, 0, 0);
    chk("R8 waits for A", excEnter, 0);
    chk("R8 not active", excActive, 0);
    chk("R5 C removed", winCount, 4);
    report(0, 1, 8'h33, 32'hAAAA, 32'hBBBB);
    chk("R9 entry one edge later", excEnter, 0);
    step();
    chk("R9 pulse", excEnter, 1);
    chk("R9 active", excActive, 1);
    chk("R9 window empty", winCount, 0);
    chk("R9 shadow count", shadowCount, 4);
    shadowSel = 0; #1;
    chk("R9 sh0 addr", shadowAddr, 30'h40);
    chk("R9 sh0 faulted", shadowFaulted, 1);
    chk("R9 sh0 status", shadowStatus, 8'h33);
    chk("R9 sh0 arg1", shadowArg1, 32'hAAAA);
    chk("R9 sh0 arg2", shadowArg2, 32'hBBBB);
    shadowSel = 1; #1;
    chk("R9 sh1 addr", shadowAddr, 30'h41);
    chk("R9 sh1 status", shadowStatus, 8'h5A);
    chk("R9 sh1 arg1", shadowArg1, 32'h1111);
    shadowSel = 2; #1;
    chk("R9 sh2 addr", shadowAddr, 30'h43);
    chk("R9 sh2 not faulted", shadowFaulted, 0);
    chk("R9 sh2 opcode", shadowOpcode, {2'b10, 30'h43});
    shadowSel = 3; #1;
    chk("R9 sh3 addr", shadowAddr, 30'h44);
    step();
    chk("R9 pulse ends", excEnter, 0);
    chk("R10 fetch refused", fetchReady, 0);
    chk("R10 no issue", issueValid, 0);
    fetch(30'h7F, 0, 0, 0);
    chk("R10 fetch ignored", winCount, 0);
    rteReq = 1;
    step();
    rteReq = 0;
    chk("R11 inactive", excActive, 0);
    chk("R11 reloaded count", winCount, 2);
    issue("R11 resume order", 0, 30'h43);
    issue("R11 next", 1, 30'h44);
  endtask

  initial begin
    t_reset();
    t_fill_and_order();
    t_safe();
    t_head_only();
    t_fault_drain();
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule